// File: doc/BRIEF.md
# I2C Master Bus-Condition Controller

This block generates the framing conditions for an I2C master and tracks whether the bus is occupied. It drives open-drain enables for SDA and SCL. An enable of 1 pulls the line low and an enable of 0 releases it. A single write event carries two control bits, `wr_busy` and `wr_inhibit`. With the inhibit bit clear, `wr_busy=1` requests a START, or a repeated START when the master already holds the bus. With the inhibit bit clear, `wr_busy=0` requests a STOP.

Every step of a generated condition lasts half of one SCL period. The period is the system clock divided by a ratio that a 4-bit rate code picks from a fixed, non-monotonic table. The bus-busy flag is not set by the writes. It follows what the controller sees on the synchronized bus lines: a START seen on the wires sets it, and a STOP seen on the wires clears it. The flag therefore also reflects conditions that other masters put on the bus.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: Rate codes 0 to 15 select the divisors 28, 40, 48, 64, 168, 100, 112, 128, 56, 80, 96, 128, 336, 200, 224, 256. Every timed step of a condition lasts exactly divisor/2 clock cycles, and the enables change only at the end of a step.
- R2: A START request from idle (both enables 0) asserts `sda_oe=1` with `scl_oe=0` for one step. It then asserts `scl_oe=1` and holds both enables at 1.
- R3: `bus_busy` goes to 1 on the third rising clock edge after SDA falls while SCL is high, judged after a two-flop synchronizer. SDA falling while SCL is low does not set it.
- R4: `bus_busy` goes to 0 on the third rising clock edge after SDA rises while SCL is high. SDA rising while SCL is low does not clear it.
- R5: A START request while holding the bus (both enables 1) performs three steps in turn: SDA released with SCL low, then both released, then SDA low with SCL released. After that it holds both lines low.
- R6: A STOP request while holding releases SCL for one step with SDA still low, and then releases SDA. A STOP request from idle first pulls both lines low for one step and then follows the same two steps.
- R7: A write with `wr_inhibit=1` changes neither enable nor `bus_busy`.
- R8: The rate code is captured only when a condition is launched and at each step boundary. A code change in the middle of a step takes effect from the next step.
- R9: Synchronous reset releases both lines and clears `bus_busy`, including in the middle of a condition.
- R10: Writes that arrive while a condition is in progress are ignored.
- R11: `bus_busy` changes only when a START or STOP is seen on the lines. A command write has no direct effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 4 | SCL divisor code |
| wr_en | input | 1 | Control write strobe, one cycle |
| wr_busy | input | 1 | Write data: 1 requests START, 0 requests STOP |
| wr_inhibit | input | 1 | Write data: 1 makes the write a no-op |
| sda_in | input | 1 | Sensed SDA level |
| scl_in | input | 1 | Sensed SCL level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| bus_busy | output | 1 | Bus occupied flag |

## Verification
The assertions check the following on every cycle:
- The busy flag responds to synchronized line conditions and stays put otherwise.
- Inhibited writes do nothing.
- The step counter stays under the selected half period.
- The enables only move at step boundaries.
- SDA is never released with SCL high unless SCL was already high, which is the STOP ordering.
- The rate code only changes at a launch or a boundary.

The complete START, repeated-START and STOP waveforms, the exact step lengths for each of the sixteen codes, the three-edge busy latency and the effect of a reset in the middle of a condition can only be shown by the bench's scenarios.

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] rate_sel,
  input  logic       wr_en,
  input  logic       wr_busy,
  input  logic       wr_inhibit,
  input  logic       sda_in,
  input  logic       scl_in,
  output logic       sda_oe,
  output logic       scl_oe,
  output logic       bus_busy
);
  localparam int DIV_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_RS_SDA, S_RS_SCL, S_ST_SDA, S_SP_LOW, S_SP_SCL
  } state_t;

  function automatic logic [DIV_W-1:0] div_of(input logic [3:0] c);
    case (c)
      4'd0:    div_of = DIV_W'(28);
      4'd1:    div_of = DIV_W'(40);
      4'd2:    div_of = DIV_W'(48);
      4'd3:    div_of = DIV_W'(64);
      4'd4:    div_of = DIV_W'(168);
      4'd5:    div_of = DIV_W'(100);
      4'd6:    div_of = DIV_W'(112);
      4'd7:    div_of = DIV_W'(128);
      4'd8:    div_of = DIV_W'(56);
      4'd9:    div_of = DIV_W'(80);
      4'd10:   div_of = DIV_W'(96);
      4'd11:   div_of = DIV_W'(128);
      4'd12:   div_of = DIV_W'(336);
      4'd13:   div_of = DIV_W'(200);
      4'd14:   div_of = DIV_W'(224);
      default: div_of = DIV_W'(256);
    endcase
  endfunction

  logic [1:0]       sda_sync, scl_sync;
  logic             sda_q, sda_s, scl_s;
  logic             start_seen, stop_seen;
  state_t           st, st_n;
  logic [3:0]       code_q;
  logic [CNT_W-1:0] cnt, half_q;
  logic [DIV_W-1:0] div_q;
  logic             active, phase_end, cmd_ok, load;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_sync <= 2'b11;
      scl_sync <= 2'b11;
      sda_q    <= 1'b1;
    end else begin
      sda_sync <= {sda_sync[0], sda_in};
      scl_sync <= {scl_sync[0], scl_in};
      sda_q    <= sda_sync[1];
    end
  end

  assign sda_s      = sda_sync[1];
  assign scl_s      = scl_sync[1];
  assign start_seen = sda_q & ~sda_s & scl_s;
  assign stop_seen  = ~sda_q & sda_s & scl_s;

  always_ff @(posedge clk) begin
    if (rst)             bus_busy <= 1'b0;
    else if (start_seen) bus_busy <= 1'b1;
    else if (stop_seen)  bus_busy <= 1'b0;
  end

  assign div_q     = div_of(code_q);
  assign half_q    = div_q[DIV_W-1:1];
  assign active    = (st != S_IDLE) && (st != S_HOLD);
  assign phase_end = active && (cnt == half_q - ONE);
  assign cmd_ok    = wr_en && !wr_inhibit && !active;
  assign load      = cmd_ok || phase_end;

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:   if (cmd_ok) st_n = wr_busy ? S_ST_SDA : S_SP_LOW;
      S_HOLD:   if (cmd_ok) st_n = wr_busy ? S_RS_SDA : S_SP_SCL;
      S_RS_SDA: if (phase_end) st_n = S_RS_SCL;
      S_RS_SCL: if (phase_end) st_n = S_ST_SDA;
      S_ST_SDA: if (phase_end) st_n = S_HOLD;
      S_SP_LOW: if (phase_end) st_n = S_SP_SCL;
      S_SP_SCL: if (phase_end) st_n = S_IDLE;
      default:  st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      code_q <= 4'd0;
    end else begin
      st <= st_n;
      if (load) begin
        cnt    <= '0;
        code_q <= rate_sel;
      end else if (active) begin
        cnt <= cnt + ONE;
      end
    end
  end

  assign sda_oe = (st == S_HOLD) || (st == S_ST_SDA) || (st == S_SP_LOW) || (st == S_SP_SCL);
  assign scl_oe = (st == S_HOLD) || (st == S_RS_SDA) || (st == S_SP_LOW);
endmodule

// File: rtl/i2c_cond_ctrl_chk.sv
module i2c_cond_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_inhibit,
  input logic             sda_oe,
  input logic             scl_oe,
  input logic             bus_busy,
  input logic             sda_q,
  input logic             sda_s,
  input logic             scl_s,
  input logic [3:0]       code_q,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] half_q,
  input logic             active,
  input logic             phase_end,
  input logic             load
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
    (sda_q && !sda_s && scl_s) |=> bus_busy); // R3
  AST_BUSY_CLR: assert property (@(posedge clk) disable iff (rst)
    (!sda_q && sda_s && scl_s) |=> !bus_busy); // R4
  AST_BUSY_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(sda_q != sda_s && scl_s) |=> $stable(bus_busy)); // R11
  AST_INHIBIT_NOP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_inhibit && !active) |=> ($stable(sda_oe) && $stable(scl_oe))); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < half_q); // R1
  AST_STEP_STABLE: assert property (@(posedge clk) disable iff (rst)
    (active && !phase_end) |=> ($stable(sda_oe) && $stable(scl_oe))); // R1
  AST_STOP_ORDER: assert property (@(posedge clk) disable iff (rst || !armed)
    ($fell(sda_oe) && !scl_oe) |-> $past(!scl_oe)); // R6
  AST_CODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(code_q) |-> $past(load)); // R8
endmodule

bind i2c_cond_ctrl i2c_cond_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_inhibit(wr_inhibit),
  .sda_oe(sda_oe), .scl_oe(scl_oe), .bus_busy(bus_busy),
  .sda_q(sda_q), .sda_s(sda_s), .scl_s(scl_s), .code_q(code_q),
  .cnt(cnt), .half_q(half_q), .active(active), .phase_end(phase_end),
  .load(load)
);

// File: tb/i2c_cond_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_cond_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] rate_sel = 4'd0;
  logic wr_en = 1'b0, wr_busy = 1'b0, wr_inhibit = 1'b0;
  logic ext_sda = 1'b0, ext_scl = 1'b0;
  logic sda_oe, scl_oe, bus_busy;
  logic sda_line, scl_line;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = !(sda_oe || ext_sda);
  assign scl_line = !(scl_oe || ext_scl);

  i2c_cond_ctrl u_dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .wr_en(wr_en),
    .wr_busy(wr_busy), .wr_inhibit(wr_inhibit), .sda_in(sda_line),
    .scl_in(scl_line), .sda_oe(sda_oe), .scl_oe(scl_oe), .bus_busy(bus_busy)
  );

  function automatic int half_of(input int c);
    int d[16] = '{28, 40, 48, 64, 168, 100, 112, 128, 56, 80, 96, 128, 336, 200, 224, 256};
    return d[c] / 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic inh);
    @(negedge clk);
    wr_en = 1'b1; wr_busy = b; wr_inhibit = inh;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_pat(input logic es, input logic ec, output int n);
    n = 0;
    while (sda_oe === es && scl_oe === ec && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic lines(input string req, input int es, input int ec);
    chk(req, {30'd0, sda_oe, scl_oe}, es * 2 + ec);
  endtask

  initial begin
    int n;
    repeat (5) @(negedge clk);
    lines("R9 reset lines", 0, 0);
    chk("R9 reset busy", int'(bus_busy), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 R2 R6: sweep all codes with START then STOP
    for (int c = 0; c < 16; c++) begin
      rate_sel = 4'(c);
      wr(1'b1, 1'b0);
      count_pat(1'b1, 1'b0, n);
      chk($sformatf("R1 R2 start step code %0d", c), n, half_of(c));
      lines("R2 hold after start", 1, 1);
      repeat (4) @(negedge clk);
      chk("R3 busy after own start", int'(bus_busy), 1);
      wr(1'b0, 1'b0);
      count_pat(1'b1, 1'b0, n);
      chk($sformatf("R1 R6 stop step code %0d", c), n, half_of(c));
      lines("R6 released after stop", 0, 0);
      repeat (4) @(negedge clk);
      chk("R4 busy after own stop", int'(bus_busy), 0);
    end

    // R5 repeated START
    rate_sel = 4'd3;
    wr(1'b1, 1'b0);
    count_pat(1'b1, 1'b0, n);
    rate_sel = 4'd9;
    wr(1'b1, 1'b0);
    count_pat(1'b0, 1'b1, n);
    chk("R5 sda release step", n, 40);
    count_pat(1'b0, 1'b0, n);
    chk("R5 both high step", n, 40);
    count_pat(1'b1, 1'b0, n);
    chk("R5 sda low step", n, 40);
    lines("R5 hold after restart", 1, 1);
    repeat (4) @(negedge clk);
    chk("R5 busy kept", int'(bus_busy), 1);

    // R8 code change mid-step
    rate_sel = 4'd6;
    wr(1'b1, 1'b0);
    rate_sel = 4'd0;
    count_pat(1'b0, 1'b1, n);
    chk("R8 first step old code", n, 56);
    count_pat(1'b0, 1'b0, n);
    chk("R8 second step new code", n, 14);
    count_pat(1'b1, 1'b0, n);
    chk("R8 third step new code", n, 14);

    // R10 write during a STOP is ignored
    rate_sel = 4'd5;
    wr(1'b0, 1'b0);
    wr(1'b1, 1'b0);
    count_pat(1'b1, 1'b0, n);
    chk("R10 stop step unaffected", n, 48);
    lines("R10 released", 0, 0);
    repeat (4) @(negedge clk);
    chk("R4 busy cleared", int'(bus_busy), 0);

    // R6 STOP from idle, R11 busy untouched
    rate_sel = 4'd1;
    wr(1'b0, 1'b0);
    count_pat(1'b1, 1'b1, n);
    chk("R6 idle stop low step", n, 20);
    count_pat(1'b1, 1'b0, n);
    chk("R6 idle stop scl step", n, 20);
    lines("R6 idle stop released", 0, 0);
    repeat (4) @(negedge clk);
    chk("R11 busy not set by write", int'(bus_busy), 0);

    // R7 inhibited writes
    begin
      int bad = 0;
      wr(1'b1, 1'b1);
      repeat (30) begin
        if (sda_oe || scl_oe || bus_busy) bad++;
        @(negedge clk);
      end
      chk("R7 inhibited start no effect", bad, 0);
    end
    rate_sel = 4'd0;
    wr(1'b1, 1'b0);
    count_pat(1'b1, 1'b0, n);
    repeat (4) @(negedge clk);
    begin
      int bad = 0;
      wr(1'b0, 1'b1);
      repeat (30) begin
        if (!sda_oe || !scl_oe || !bus_busy) bad++;
        @(negedge clk);
      end
      chk("R7 inhibited stop no effect", bad, 0);
    end
    wr(1'b0, 1'b0);
    count_pat(1'b1, 1'b0, n);
    repeat (4) @(negedge clk);

    // R3 R4 external conditions
    ext_sda = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 busy not yet after 2 edges", int'(bus_busy), 0);
    @(negedge clk);
    chk("R3 busy after 3 edges", int'(bus_busy), 1);
    ext_scl = 1'b1; repeat (4) @(negedge clk);
    ext_sda = 1'b0; repeat (4) @(negedge clk);
    chk("R4 sda rise with scl low ignored", int'(bus_busy), 1);
    ext_scl = 1'b0; repeat (4) @(negedge clk);
    ext_sda = 1'b1; repeat (4) @(negedge clk);
    ext_sda = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 busy held after 2 edges", int'(bus_busy), 1);
    @(negedge clk);
    chk("R4 busy cleared after 3 edges", int'(bus_busy), 0);
    ext_scl = 1'b1; repeat (4) @(negedge clk);
    ext_sda = 1'b1; repeat (4) @(negedge clk);
    ext_scl = 1'b0; repeat (4) @(negedge clk);
    chk("R3 sda fall with scl low ignored", int'(bus_busy), 0);
    ext_sda = 1'b0; repeat (4) @(negedge clk);

    // R9 reset mid-condition
    rate_sel = 4'd12;
    wr(1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk("R9 busy before reset", int'(bus_busy), 1);
    rst = 1'b1;
    @(negedge clk);
    lines("R9 mid reset lines", 0, 0);
    chk("R9 mid reset busy", int'(bus_busy), 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    lines("R9 idle after reset", 0, 0);
    chk("R9 busy stays clear", int'(bus_busy), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule